// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block runs on the main side of a system that has a replaceable module. It decides whether the module is authentic by running one or more challenge-response rounds over a single-wire link. In each round it takes a fresh 32-bit challenge from a random source. It waits for the module's acknowledge, then sends an encrypt opcode that selects one of two keys. After a mandatory gap it sends the challenge. It then waits out the module's minimum response time and accepts the 32-bit response. The response is passed to an external decryption engine. The round succeeds only if the decrypted word equals the latched challenge bit for bit.

The line-level work is done by blocks outside this one: a pulse-position transmitter, a receiver that detects the acknowledge pattern and assembles response words, and the cipher. The sequencer reaches these blocks through valid/ready streams (random source, transmitter, receiver) and a request/done pair (decryptor). On the transmitter stream, a word that has been offered stays on the bus unchanged until `tx_ready` accepts it. The random and receive streams are consumed only when the sequencer raises the matching ready. A producer may hold valid high for as long as it needs, and nothing is lost while ready is low. A watchdog ends a run with a timeout status if the acknowledge or the response does not arrive in time.

Top module: `auth_seq`

## Requirements
- R1: A `start` pulse seen while idle latches `key_sel` and `rounds`, and `busy` rises on the next cycle. A `start` seen while busy has no effect on the run in progress, including its key.
- R2: At the beginning of every round, `rnd_ready` is raised, and the challenge is latched on the cycle where `rnd_valid` and `rnd_ready` are both high. `rnd_ready` is low in every other phase.
- R3: No opcode is offered until an `ack_seen` pulse arrives while the sequencer waits for one. Every round waits for a fresh acknowledge, and acknowledges that arrive in other phases are discarded.
- R4: The opcode is offered with `tx_bits` = 5 in `tx_data[4:0]`: 5'b10001 when the latched key select is 0 and 5'b10101 when it is 1.
- R5: The challenge packet (`tx_bits` = 32, `tx_data` = challenge) is offered no sooner than `OTD_CYC` cycles after the `tx_done` that ends the opcode.
- R6: `rx_ready` stays low for `RT_CYC` cycles after the `tx_done` that ends the challenge packet. After that, the response is taken on the first `rx_valid`/`rx_ready` handshake.
- R7: `dec_req` is held high, with `dec_data` equal to the received response, until `dec_done`.
- R8: `pass` is set only if `dec_result` equals the round's challenge in every round. The number of rounds is `rounds`, and a value of 0 runs one round.
- R9: The first mismatch ends the run with `pass` = 0 and `timeout` = 0, and no further challenge is requested.
- R10: If no acknowledge arrives within `WDOG_CYC` cycles, or no response arrives within `WDOG_CYC` cycles after the guard ends, the run ends with `pass` = 0 and `timeout` = 1.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_bits` hold their values.
- R12: `done` is a one-cycle pulse in the cycle where `busy` falls. `pass` and `timeout` keep their values until the next accepted `start`. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an authentication run |
| key_sel | input | 1 | Key choice: 0 selects key 1, 1 selects key 2 |
| rounds | input | ROUND_W | Number of rounds (0 means 1) |
| rnd_valid | input | 1 | Random word available |
| rnd_ready | output | 1 | Sequencer takes a random word |
| rnd_data | input | 32 | Random word |
| ack_seen | input | 1 | Pulse: acknowledge pattern received |
| tx_valid | output | 1 | Word offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts word |
| tx_data | output | 32 | Opcode or challenge, LSB-aligned |
| tx_bits | output | 6 | Number of bits to send (5 or 32) |
| tx_done | input | 1 | Pulse: word fully sent on the line |
| rx_valid | input | 1 | Response word available |
| rx_ready | output | 1 | Sequencer accepts response |
| rx_data | input | 32 | Response word |
| dec_req | output | 1 | Decryption request |
| dec_data | output | 32 | Word to decrypt |
| dec_done | input | 1 | Pulse: decryption finished |
| dec_result | input | 32 | Decrypted word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Pulse: run finished |
| pass | output | 1 | Last run authenticated the module |
| timeout | output | 1 | Last run ended on the watchdog |

## Verification
The bench builds the block with `OTD_CYC` = 20, `RT_CYC` = 40, `WDOG_CYC` = 150 and `ROUND_W` = 4. The cycle counts of the gap, the response guard and both watchdog paths can therefore be measured exactly in a short run. With a 4-bit round count, runs of zero, one and several rounds are cheap, including a mismatch placed on any round. The bench offers responses early, so the guard window has to be what holds them back, and it pulses stray acknowledges and starts to show they are discarded.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

  localparam int BLK_W = 32;
  localparam int LEN_W = 6;

  localparam logic [4:0]       OPC_ENC_K1 = 5'b10001;
  localparam logic [4:0]       OPC_ENC_K2 = 5'b10101;
  localparam logic [LEN_W-1:0] LEN_OPC    = 6'd5;
  localparam logic [LEN_W-1:0] LEN_BLK    = 6'd32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DRAW,
    ST_ACK,
    ST_CMD,
    ST_CMD_FLY,
    ST_GAP,
    ST_DATA,
    ST_DATA_FLY,
    ST_GUARD,
    ST_RESP,
    ST_DECRYPT,
    ST_CHECK,
    ST_FINISH
  } seq_state_e;

endpackage

// File: rtl/auth_wait_timer.sv
module auth_wait_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/auth_round_ctl.sv
module auth_round_ctl #(
  parameter int BLK_W   = 32,
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [ROUND_W-1:0] rounds_in,
  input  logic               take_ch,
  input  logic [BLK_W-1:0]   ch_in,
  input  logic               take_res,
  input  logic [BLK_W-1:0]   res_in,
  input  logic               advance,
  output logic [BLK_W-1:0]   challenge,
  output logic               match,
  output logic               last_round
);

  logic [ROUND_W-1:0] left_q;
  logic [BLK_W-1:0]   ch_q;
  logic               match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      ch_q    <= '0;
      match_q <= 1'b0;
    end else begin
      if (arm)
        left_q <= (rounds_in == '0) ? ROUND_W'(1) : rounds_in;
      else if (advance)
        left_q <= left_q - 1'b1;
      if (take_ch)
        ch_q <= ch_in;
      if (take_res)
        match_q <= (res_in == ch_q);
    end
  end

  assign challenge  = ch_q;
  assign match      = match_q;
  assign last_round = (left_q <= ROUND_W'(1));

  AST_ROUND_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (left_q > ROUND_W'(1))); // R8

endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_seq_pkg::*;
#(
  parameter int ROUND_W  = 8,
  parameter int OTD_CYC  = 90000,
  parameter int RT_CYC   = 325000,
  parameter int WDOG_CYC = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               key_sel,
  input  logic [ROUND_W-1:0] rounds,
  input  logic               rnd_valid,
  output logic               rnd_ready,
  input  logic [31:0]        rnd_data,
  input  logic               ack_seen,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [31:0]        tx_data,
  output logic [5:0]         tx_bits,
  input  logic               tx_done,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [31:0]        rx_data,
  output logic               dec_req,
  output logic [31:0]        dec_data,
  input  logic               dec_done,
  input  logic [31:0]        dec_result,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               timeout
);

  localparam int WAIT_A = (OTD_CYC > RT_CYC) ? OTD_CYC : RT_CYC;
  localparam int WAIT_M = (WDOG_CYC > WAIT_A) ? WDOG_CYC : WAIT_A;
  localparam int CNT_W  = $clog2(WAIT_M + 1);

  seq_state_e state_q, state_n;
  logic             key_q;
  logic [BLK_W-1:0] resp_q;
  logic             pass_q, to_q;

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_exp;

  logic             advance;
  logic             fin_pass, fin_to;
  logic [BLK_W-1:0] challenge;
  logic             match, last_round;
  logic             arm, take_ch, take_res;

  assign arm      = (state_q == ST_IDLE) && start;
  assign take_ch  = (state_q == ST_DRAW) && rnd_valid;
  assign take_res = (state_q == ST_DECRYPT) && dec_done;

  auth_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  auth_round_ctl #(.BLK_W(BLK_W), .ROUND_W(ROUND_W)) u_rounds (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .rounds_in  (rounds),
    .take_ch    (take_ch),
    .ch_in      (rnd_data),
    .take_res   (take_res),
    .res_in     (dec_result),
    .advance    (advance),
    .challenge  (challenge),
    .match      (match),
    .last_round (last_round)
  );

  always_comb begin
    state_n  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    advance  = 1'b0;
    fin_pass = 1'b0;
    fin_to   = 1'b0;
    case (state_q)
      ST_IDLE:     if (start) state_n = ST_DRAW;
      ST_DRAW:     if (rnd_valid) begin
                     state_n = ST_ACK;
                     t_load  = 1'b1;
                     t_val   = CNT_W'(WDOG_CYC - 1);
                   end
      ST_ACK:      if (ack_seen) state_n = ST_CMD;
                   else if (t_exp) begin
                     state_n = ST_FINISH;
                     fin_to  = 1'b1;
                   end
      ST_CMD:      if (tx_ready) state_n = ST_CMD_FLY;
      ST_CMD_FLY:  if (tx_done) begin
                     state_n = ST_GAP;
                     t_load  = 1'b1;
                     t_val   = CNT_W'(OTD_CYC - 1);
                   end
      ST_GAP:      if (t_exp) state_n = ST_DATA;
      ST_DATA:     if (tx_ready) state_n = ST_DATA_FLY;
      ST_DATA_FLY: if (tx_done) begin
                     state_n = ST_GUARD;
                     t_load  = 1'b1;
                     t_val   = CNT_W'(RT_CYC - 1);
                   end
      ST_GUARD:    if (t_exp) begin
                     state_n = ST_RESP;
                     t_load  = 1'b1;
                     t_val   = CNT_W'(WDOG_CYC - 1);
                   end
      ST_RESP:     if (rx_valid) state_n = ST_DECRYPT;
                   else if (t_exp) begin
                     state_n = ST_FINISH;
                     fin_to  = 1'b1;
                   end
      ST_DECRYPT:  if (dec_done) state_n = ST_CHECK;
      ST_CHECK:    if (!match) state_n = ST_FINISH;
                   else if (last_round) begin
                     state_n  = ST_FINISH;
                     fin_pass = 1'b1;
                   end else begin
                     state_n = ST_DRAW;
                     advance = 1'b1;
                   end
      ST_FINISH:   state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      key_q   <= 1'b0;
      resp_q  <= '0;
      pass_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      if (arm) begin
        key_q  <= key_sel;
        pass_q <= 1'b0;
        to_q   <= 1'b0;
      end
      if (state_q == ST_RESP && rx_valid)
        resp_q <= rx_data;
      if (state_n == ST_FINISH && state_q != ST_FINISH) begin
        pass_q <= fin_pass;
        to_q   <= fin_to;
      end
    end
  end

  assign rnd_ready = (state_q == ST_DRAW);
  assign tx_valid  = (state_q == ST_CMD) || (state_q == ST_DATA);
  assign tx_bits   = (state_q == ST_DATA) ? LEN_BLK : LEN_OPC;
  assign tx_data   = (state_q == ST_DATA) ? challenge
                   : {27'd0, (key_q ? OPC_ENC_K2 : OPC_ENC_K1)};
  assign rx_ready  = (state_q == ST_RESP);
  assign dec_req   = (state_q == ST_DECRYPT);
  assign dec_data  = resp_q;
  assign done      = (state_q == ST_FINISH);
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
  assign pass      = pass_q;
  assign timeout   = to_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_bits))); // R11
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !dec_done) |=> (dec_req && $stable(dec_data))); // R7
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, dec_req, rnd_ready})); // R2
  AST_OPC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_bits == 6'd5) |-> (tx_data[4:0] == 5'b10001 || tx_data[4:0] == 5'b10101)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(pass && timeout)); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R12

endmodule

// File: tb/auth_seq_test.sv
module auth_seq_test;

  localparam int ROUND_W  = 4;
  localparam int OTD_CYC  = 20;
  localparam int RT_CYC   = 40;
  localparam int WDOG_CYC = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, key_sel = 1'b0;
  logic [ROUND_W-1:0] rounds = '0;
  logic rnd_valid = 1'b0, rnd_ready;
  logic [31:0] rnd_data = '0;
  logic ack_seen = 1'b0;
  logic tx_valid, tx_ready = 1'b0, tx_done = 1'b0;
  logic [31:0] tx_data;
  logic [5:0] tx_bits;
  logic rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic dec_req, dec_done = 1'b0;
  logic [31:0] dec_data, dec_result = '0;
  logic busy, done, pass, timeout;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  auth_seq #(.ROUND_W(ROUND_W), .OTD_CYC(OTD_CYC), .RT_CYC(RT_CYC), .WDOG_CYC(WDOG_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_sel(key_sel), .rounds(rounds),
    .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_data(rnd_data),
    .ack_seen(ack_seen),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_bits(tx_bits), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .dec_req(dec_req), .dec_data(dec_data), .dec_done(dec_done), .dec_result(dec_result),
    .busy(busy), .done(done), .pass(pass), .timeout(timeout)
  );

  function automatic logic [31:0] key_word(input bit k);
    return k ? 32'hC3A5_5A3C : 32'h1F2E_3D4C;
  endfunction

  function automatic logic [31:0] enc(input logic [31:0] x, input bit k);
    logic [31:0] t = x ^ key_word(k);
    return {t[26:0], t[31:27]};
  endfunction

  function automatic logic [31:0] dec(input logic [31:0] y, input bit k);
    return {y[4:0], y[31:5]} ^ key_word(k);
  endfunction

  function automatic logic [4:0] exp_opc(input bit k);
    return k ? 5'b10101 : 5'b10001;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fault: 0 none, 1 no acknowledge in round 1, 2 no response in round 1
  task automatic run(input int rounds_cfg, input bit key, input int bad_round, input int fault);
    int eff;
    bit stop;
    bit early;
    int cnt;
    logic [31:0] ch, resp, hold_d;
    eff = (rounds_cfg == 0) ? 1 : rounds_cfg;
    stop = 0;
    @(negedge clk);
    rounds = ROUND_W'(rounds_cfg); key_sel = key; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    for (int r = 1; r <= eff && !stop; r++) begin
      cnt = 0;
      while (!rnd_ready && cnt < 1000) begin @(negedge clk); cnt++; end
      chk(rnd_ready == 1'b1, "R2 challenge requested", 32'(rnd_ready), 32'd1);
      ch = $urandom;
      rnd_valid = 1'b1; rnd_data = ch;
      @(negedge clk);
      rnd_valid = 1'b0;
      chk(rnd_ready == 1'b0, "R2 ready drops after handshake", 32'(rnd_ready), 32'd0);
      if (fault == 1) begin
        cnt = 1;
        while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt >= WDOG_CYC && cnt <= WDOG_CYC + 3, "R10 ack watchdog cycles", 32'(cnt), 32'(WDOG_CYC + 1));
        chk(timeout == 1'b1 && pass == 1'b0, "R10 ack timeout status", {30'd0, timeout, pass}, 32'd2);
        stop = 1;
      end else begin
        early = 0;
        repeat (2 + $urandom % 4) begin
          @(negedge clk);
          if (tx_valid) early = 1;
        end
        chk(!early, "R3 no opcode before acknowledge", 32'(early), 32'd0);
        ack_seen = 1'b1;
        @(negedge clk);
        ack_seen = 1'b0;
        cnt = 0;
        while (!tx_valid && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(tx_bits == 6'd5, "R4 opcode length", 32'(tx_bits), 32'd5);
        chk(tx_data == {27'd0, exp_opc(key)}, "R4 opcode value", tx_data, {27'd0, exp_opc(key)});
        hold_d = tx_data;
        repeat (1 + $urandom % 3) @(negedge clk);
        chk(tx_valid && tx_data == hold_d, "R11 opcode held under back-pressure", tx_data, hold_d);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk(tx_valid == 1'b0, "R11 valid drops after accept", 32'(tx_valid), 32'd0);
        repeat (2) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        cnt = 1;
        while (!tx_valid && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt >= OTD_CYC && cnt <= OTD_CYC + 3, "R5 gap before challenge", 32'(cnt), 32'(OTD_CYC + 1));
        chk(tx_bits == 6'd32 && tx_data == ch, "R5 challenge packet", tx_data, ch);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        resp = enc(ch, key);
        if (fault == 2) begin
          cnt = 1;
          while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
          chk(cnt >= RT_CYC + WDOG_CYC && cnt <= RT_CYC + WDOG_CYC + 3, "R10 response watchdog cycles",
              32'(cnt), 32'(RT_CYC + WDOG_CYC + 1));
          chk(timeout == 1'b1 && pass == 1'b0, "R10 response timeout status", {30'd0, timeout, pass}, 32'd2);
          stop = 1;
        end else begin
          rx_valid = 1'b1; rx_data = resp;
          cnt = 1;
          while (!rx_ready && cnt < 1000) begin @(negedge clk); cnt++; end
          chk(cnt >= RT_CYC && cnt <= RT_CYC + 3, "R6 response guard", 32'(cnt), 32'(RT_CYC + 1));
          @(negedge clk);
          rx_valid = 1'b0;
          cnt = 0;
          while (!dec_req && cnt < 1000) begin @(negedge clk); cnt++; end
          chk(dec_req && dec_data == resp, "R7 decrypt request data", dec_data, resp);
          ack_seen = 1'b1; start = 1'b1; key_sel = ~key;
          @(negedge clk);
          ack_seen = 1'b0; start = 1'b0; key_sel = key;
          repeat (1 + $urandom % 3) @(negedge clk);
          chk(dec_req && dec_data == resp, "R7 request held until done", dec_data, resp);
          dec_result = (r == bad_round) ? (ch ^ 32'h0000_0100) : dec(resp, key);
          dec_done = 1'b1;
          @(negedge clk);
          dec_done = 1'b0;
          if (r == bad_round) stop = 1;
        end
      end
    end
    if (fault == 0) begin
      early = 0;
      cnt = 0;
      while (!done && cnt < 1000) begin
        if (rnd_ready) early = 1;
        @(negedge clk); cnt++;
      end
      chk(!early, "R9 no challenge after final round", 32'(early), 32'd0);
      if (bad_round >= 1 && bad_round <= eff) begin
        chk(pass == 1'b0 && timeout == 1'b0, "R9 mismatch fails", {30'd0, timeout, pass}, 32'd0);
      end else begin
        chk(pass == 1'b1 && timeout == 1'b0, "R8 all rounds match", {30'd0, timeout, pass}, 32'd1);
      end
    end
    chk(done == 1'b1 && busy == 1'b0, "R12 done with busy low", {30'd0, done, busy}, 32'd2);
    hold_d = {30'd0, timeout, pass};
    @(negedge clk);
    chk(done == 1'b0, "R12 done single cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk({30'd0, timeout, pass} == hold_d, "R12 status held", {30'd0, timeout, pass}, hold_d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected 0", 150000);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0 && timeout == 0, "R12 reset outputs",
        {28'd0, busy, done, pass, timeout}, 32'd0);
    chk(tx_valid == 0 && rnd_ready == 0 && rx_ready == 0 && dec_req == 0, "R12 reset strobes",
        {28'd0, tx_valid, rnd_ready, rx_ready, dec_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1, 1'b0, 0, 0);
    run(3, 1'b1, 0, 0);
    run(0, 1'b0, 0, 0);
    run(4, 1'b1, 2, 0);
    run(2, 1'b0, 2, 0);
    run(2, 1'b1, 0, 1);
    run(1, 1'b0, 0, 2);
    for (int i = 0; i < 6; i++) begin
      run(int'(1 + $urandom % 3), bit'($urandom % 2), int'($urandom % 5), 0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule